// File: doc/BRIEF.md
# Guest System-Mask Update Assist

This controller performs the three system-mask instructions (replace the mask, AND into the mask, OR into the mask) directly on a guest's virtual program status word, which is kept in memory. The mask is the top byte (bits 31:24) of that word. A hypervisor control register points at an 8-byte-aligned control block. The controller reads that block to find the guest's virtual control register 0 and virtual status word. It then applies the update, or refuses it and leaves memory untouched. A refusal hands the instruction back to the hypervisor's software path.

The controller must refuse any update the hypervisor has to observe. That covers toggling the translation-enable or event-monitor bits (mask 0x44) in extended mode, enabling an interrupt class while a guest interrupt is pending, a trap flag in virtual control register 0, and an access gate in the control block. After a successful AND or OR, the old mask byte is stored at the operand address before the status word is rewritten.

Top module: `sm_assist`

## Requirements
- R1: After reset `busy`, `done`, `decline` and `mem_req` are all low, and they stay low until `start` is seen with a valid op.
- R2: When `ctl_reg` bit 24 is set, the controller reads block word 5 and refuses unless bit 23 of that word is set. When bit 24 is clear, word 5 is not consulted.
- R3: Block word 1 points at virtual CR0. Replace and OR are refused if virtual CR0 bit 30 is set. AND ignores that bit.
- R4: Replace in extended mode (status word bit 19 set) reads the new mask from the operand byte. It is refused if the new mask has any bit of 0xB8 set, if (old XOR new) has any bit of 0x44 set, or if an interrupt is pending and (old XOR new) AND new AND 0x03 is nonzero.
- R5: Replace in basic mode is refused only if an interrupt is pending and (old XOR new) AND new is nonzero. Otherwise the operand byte becomes bits 31:24 of the status word, and bits 23:0 are kept. The `imm` input is ignored.
- R6: AND stores the old mask byte at the operand address and sets the mask to old AND `imm`. In extended mode it is refused unless both bits of 0x44 in `imm` are set.
- R7: OR stores the old mask byte and sets the mask to old OR `imm`. With chg = new XOR old: in extended mode it is refused if chg has any bit of 0xFC set, or if an interrupt is pending and chg AND 0x03 is nonzero. In basic mode it is refused if an interrupt is pending and chg is nonzero.
- R8: The operand-byte write lands in the cycle right before the status-word write, and `done` is high in the status-word write cycle. A refused update performs no memory write.
- R9: `done` and `decline` are one-cycle pulses and never high together.
- R10: Op codes are 0 for replace, 1 for AND, 2 for OR. Op 3 is refused in the same cycle as `start`, with no memory access. `start` is ignored while `busy` is high.
- R11: Block word 2 points at the status word, and bit 31 of that pointer word is the pending-interrupt flag. The block base byte address is `ctl_reg[23:3]`×8. Pointers use bits 23:0. `mem_addr` is a word address. Read data is valid on `mem_rdata` one cycle after a read request. Byte k of a word occupies bits 31−8k..24−8k, and `mem_be[i]` enables bits 8i+7..8i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an update (sampled when idle) |
| op | input | 2 | 0 replace, 1 AND, 2 OR, 3 reserved |
| imm | input | 8 | Immediate mask for AND/OR |
| opnd_addr | input | AW | Operand byte address |
| ctl_reg | input | 32 | Hypervisor control register (block base, gate enable) |
| busy | output | 1 | Update in progress |
| done | output | 1 | Update committed (pulse) |
| decline | output | 1 | Update refused, memory unchanged (pulse) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW-2 | Word address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after request |

## Verification
A wrong internal state appears at the memory port within one access. A pointer captured from the wrong cycle sends the next request to a wrong word address. A wrong refusal decision either writes the status word when it should stay untouched, or raises `decline` where `done` belonged. Both show by the end of the same update, about ten cycles after `start`. A lane-select fault shows as a neighbouring byte of the operand word changing, or as a wrong byte reaching the mask. An ordering fault shows as the two writes appearing in the wrong order or with a gap between them.

// File: rtl/sm_assist_pkg.sv
package sm_assist_pkg;

   typedef enum logic [1:0] {
      OP_SET = 2'd0,
      OP_AND = 2'd1,
      OP_OR  = 2'd2,
      OP_RSV = 2'd3
   } sm_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_R_GATE,
      ST_C_GATE,
      ST_R_P1,
      ST_R_CR0,
      ST_R_P2,
      ST_R_PSW,
      ST_G_PSW,
      ST_G_OPR,
      ST_EVAL,
      ST_W_OPR,
      ST_W_PSW
   } sm_state_e;

   localparam int CTL_GATE_BIT  = 24;
   localparam int GATE_OK_BIT   = 23;
   localparam int VCR0_TRAP_BIT = 30;
   localparam int PEND_BIT      = 31;
   localparam int EXT_MODE_BIT  = 19;

   localparam logic [7:0] SET_EXT_MBZ  = 8'hB8;
   localparam logic [7:0] XLAT_MON     = 8'h44;
   localparam logic [7:0] EXT_IRQ_BITS = 8'h03;
   localparam logic [7:0] OR_EXT_FIXED = 8'hFC;

endpackage

// File: rtl/sm_policy.sv
module sm_policy
   import sm_assist_pkg::*;
(
   input  sm_op_e     op,
   input  logic [7:0] old_m,
   input  logic [7:0] arg,
   input  logic       ext,
   input  logic       pend,
   output logic [7:0] new_m,
   output logic       refuse
);

   logic [7:0] chg;

   always_comb begin
      case (op)
         OP_SET:  new_m = arg;
         OP_AND:  new_m = old_m & arg;
         OP_OR:   new_m = old_m | arg;
         default: new_m = old_m;
      endcase
      chg = old_m ^ new_m;

      case (op)
         OP_SET:
            if (ext)
               refuse = (|(new_m & SET_EXT_MBZ)) || (|(chg & XLAT_MON)) ||
                        (pend && (|(chg & new_m & EXT_IRQ_BITS)));
            else
               refuse = pend && (|(chg & new_m));
         OP_AND:
            refuse = ext && ((arg & XLAT_MON) != XLAT_MON);
         OP_OR:
            if (ext)
               refuse = (|(chg & OR_EXT_FIXED)) || (pend && (|(chg & EXT_IRQ_BITS)));
            else
               refuse = pend && (|chg);
         default:
            refuse = 1'b1;
      endcase
   end

endmodule

// File: rtl/sm_lane.sv
module sm_lane #(
   parameter bit BIG_END = 1'b1
) (
   input  logic [1:0]  off,
   input  logic [31:0] word,
   output logic [7:0]  sel_o,
   output logic [3:0]  be_o
);

   logic [1:0] lane;

   generate
      if (BIG_END) begin : g_big
         assign lane = 2'd3 - off;
      end else begin : g_little
         assign lane = off;
      end
   endgenerate

   assign sel_o = word[{lane, 3'b000} +: 8];
   assign be_o  = 4'b0001 << lane;

endmodule

// File: rtl/sm_assist.sv
module sm_assist
   import sm_assist_pkg::*;
#(
   parameter int AW       = 24,
   parameter bit BIG_END  = 1'b1,
   parameter int OFS_GATE = 5,
   parameter int OFS_VCR0 = 1,
   parameter int OFS_VPSW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    op,
   input  logic [7:0]    imm,
   input  logic [AW-1:0] opnd_addr,
   input  logic [31:0]   ctl_reg,
   output logic          busy,
   output logic          done,
   output logic          decline,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-3:0] mem_addr,
   output logic [3:0]    mem_be,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata
);

   localparam int WA = AW - 2;
   localparam logic [WA-1:0] A_GATE = WA'(OFS_GATE);
   localparam logic [WA-1:0] A_VCR0 = WA'(OFS_VCR0);
   localparam logic [WA-1:0] A_VPSW = WA'(OFS_VPSW);

   initial begin : p_param_chk
      assert (AW >= 8 && AW <= 32) else $error("AW out of range");
      assert (OFS_GATE < 8 && OFS_VCR0 < 8 && OFS_VPSW < 8) else $error("block offset too large");
   end

   sm_state_e     st, nxt;
   sm_op_e        op_q;
   logic [7:0]    arg_q;
   logic [AW-1:0] addr_q;
   logic [WA-1:0] blk_q;
   logic [WA-1:0] pptr_q;
   logic          pend_q;
   logic [31:0]   vpsw_q;

   logic [7:0]    lane_byte;
   logic [3:0]    lane_be;
   logic [7:0]    pol_new;
   logic          pol_ref;

   sm_lane #(.BIG_END(BIG_END)) u_lane (
      .off   (addr_q[1:0]),
      .word  (mem_rdata),
      .sel_o (lane_byte),
      .be_o  (lane_be)
   );

   sm_policy u_policy (
      .op     (op_q),
      .old_m  (vpsw_q[31:24]),
      .arg    (arg_q),
      .ext    (vpsw_q[EXT_MODE_BIT]),
      .pend   (pend_q),
      .new_m  (pol_new),
      .refuse (pol_ref)
   );

   always_comb begin
      nxt       = st;
      busy      = (st != ST_IDLE);
      done      = 1'b0;
      decline   = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_be    = '0;
      mem_wdata = '0;
      case (st)
         ST_IDLE:
            if (start) begin
               if (op == OP_RSV) decline = 1'b1;
               else nxt = ctl_reg[CTL_GATE_BIT] ? ST_R_GATE : ST_R_P1;
            end
         ST_R_GATE: begin
            mem_req  = 1'b1;
            mem_addr = blk_q + A_GATE;
            nxt      = ST_C_GATE;
         end
         ST_C_GATE:
            if (!mem_rdata[GATE_OK_BIT]) begin
               decline = 1'b1;
               nxt     = ST_IDLE;
            end else begin
               mem_req  = 1'b1;
               mem_addr = blk_q + A_VCR0;
               nxt      = ST_R_CR0;
            end
         ST_R_P1: begin
            mem_req  = 1'b1;
            mem_addr = blk_q + A_VCR0;
            nxt      = ST_R_CR0;
         end
         ST_R_CR0: begin
            mem_req  = 1'b1;
            mem_addr = mem_rdata[AW-1:2];
            nxt      = ST_R_P2;
         end
         ST_R_P2:
            if (op_q != OP_AND && mem_rdata[VCR0_TRAP_BIT]) begin
               decline = 1'b1;
               nxt     = ST_IDLE;
            end else begin
               mem_req  = 1'b1;
               mem_addr = blk_q + A_VPSW;
               nxt      = ST_R_PSW;
            end
         ST_R_PSW: begin
            mem_req  = 1'b1;
            mem_addr = mem_rdata[AW-1:2];
            nxt      = ST_G_PSW;
         end
         ST_G_PSW:
            if (op_q == OP_SET) begin
               mem_req  = 1'b1;
               mem_addr = addr_q[AW-1:2];
               nxt      = ST_G_OPR;
            end else begin
               nxt = ST_EVAL;
            end
         ST_G_OPR:
            nxt = ST_EVAL;
         ST_EVAL:
            if (pol_ref) begin
               decline = 1'b1;
               nxt     = ST_IDLE;
            end else begin
               nxt = (op_q == OP_SET) ? ST_W_PSW : ST_W_OPR;
            end
         ST_W_OPR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = addr_q[AW-1:2];
            mem_be    = lane_be;
            mem_wdata = {4{vpsw_q[31:24]}};
            nxt       = ST_W_PSW;
         end
         ST_W_PSW: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = pptr_q;
            mem_be    = 4'hF;
            mem_wdata = {pol_new, vpsw_q[23:0]};
            done      = 1'b1;
            nxt       = ST_IDLE;
         end
         default:
            nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         op_q   <= OP_SET;
         arg_q  <= '0;
         addr_q <= '0;
         blk_q  <= '0;
         pptr_q <= '0;
         pend_q <= 1'b0;
         vpsw_q <= '0;
      end else begin
         st <= nxt;
         case (st)
            ST_IDLE:
               if (start && op != OP_RSV) begin
                  op_q   <= sm_op_e'(op);
                  arg_q  <= imm;
                  addr_q <= opnd_addr;
                  blk_q  <= {ctl_reg[AW-1:3], 1'b0};
               end
            ST_R_PSW: begin
               pptr_q <= mem_rdata[AW-1:2];
               pend_q <= mem_rdata[PEND_BIT];
            end
            ST_G_PSW: vpsw_q <= mem_rdata;
            ST_G_OPR: arg_q  <= lane_byte;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sm_assist_chk.sv
module sm_assist_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [1:0] op,
   input logic       busy,
   input logic       done,
   input logic       decline,
   input logic       mem_req,
   input logic       mem_we,
   input logic [3:0] mem_be
);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!done && !(mem_req && mem_we)));

   a_r8_psw_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (mem_req && mem_we && mem_be == 4'hF));

   a_r8_byte_then_psw: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_be != 4'hF) |=> done);

   a_r8_no_write_on_decline: assert property (@(posedge clk) disable iff (!rst_n)
      decline |-> !mem_we);

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && decline));

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_reserved_op: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op == 2'd3) |-> (decline && !mem_req));

   a_r11_lane_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> ($countones(mem_be) == 1 || mem_be == 4'hF));

endmodule

bind sm_assist sm_assist_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .op      (op),
   .busy    (busy),
   .done    (done),
   .decline (decline),
   .mem_req (mem_req),
   .mem_we  (mem_we),
   .mem_be  (mem_be)
);

// File: tb/sm_assist_test.sv
`timescale 1ns/1ps
module sm_assist_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [7:0]  imm = 8'h00;
   logic [23:0] opnd_addr = '0;
   logic [31:0] ctl_reg = '0;
   logic        busy, done, decline, mem_req, mem_we;
   logic [21:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;

   logic [31:0] mem [256];

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   sm_assist uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .imm(imm),
      .opnd_addr(opnd_addr), .ctl_reg(ctl_reg), .busy(busy), .done(done),
      .decline(decline), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[7:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
         end else begin
            mem_rdata <= mem[mem_addr[7:0]];
         end
      end
   end

   // fields: op, arg, off, old, ext, pend, gate_en, gate_ok, vcr_trap, exp_decline, exp_mask
   localparam int NV = 22;
   localparam logic [41:0] VEC [NV] = '{
      {2'd0, 8'hA5, 2'd0, 8'h12, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 8'hA5, 8'h00},
      {2'd0, 8'hF1, 2'd1, 8'hF0, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1, 8'h00, 8'h00},
      {2'd0, 8'h0F, 2'd2, 8'hFF, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0, 8'h0F, 8'h00},
      {2'd0, 8'h08, 2'd3, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'h00, 8'h00},
      {2'd0, 8'h03, 2'd0, 8'h07, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'h00, 8'h00},
      {2'd0, 8'h07, 2'd1, 8'h04, 1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1, 8'h00, 8'h00},
      {2'd0, 8'h05, 2'd2, 8'h07, 1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0, 8'h05, 8'h00},
      {2'd0, 8'h07, 2'd3, 8'h04, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0, 8'h07, 8'h00},
      {2'd0, 8'h11, 2'd0, 8'h22, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1, 8'h00, 8'h00},
      {2'd1, 8'h0F, 2'd2, 8'hA5, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 8'h05, 8'h00},
      {2'd1, 8'h40, 2'd0, 8'h47, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'h00, 8'h00},
      {2'd1, 8'h44, 2'd1, 8'h47, 1'b1,1'b1,1'b0,1'b0,1'b1, 1'b0, 8'h44, 8'h00},
      {2'd2, 8'h03, 2'd1, 8'h10, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 8'h13, 8'h00},
      {2'd2, 8'h01, 2'd2, 8'h10, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1, 8'h00, 8'h00},
      {2'd2, 8'h03, 2'd3, 8'h13, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0, 8'h13, 8'h00},
      {2'd2, 8'h08, 2'd0, 8'h04, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'h00, 8'h00},
      {2'd2, 8'h01, 2'd1, 8'h04, 1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1, 8'h00, 8'h00},
      {2'd2, 8'h03, 2'd3, 8'h44, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0, 8'h47, 8'h00},
      {2'd2, 8'h01, 2'd0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1, 8'h00, 8'h00},
      {2'd0, 8'h33, 2'd0, 8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1, 8'h00, 8'h00},
      {2'd1, 8'hFF, 2'd2, 8'h3C, 1'b0,1'b0,1'b1,1'b1,1'b0, 1'b0, 8'h3C, 8'h00},
      {2'd0, 8'h47, 2'd1, 8'h47, 1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0, 8'h47, 8'h00}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] put_byte(input logic [31:0] w, input logic [1:0] k, input logic [7:0] b);
      int sh = 24 - 8 * int'(k);
      return (w & ~(32'hFF << sh)) | ({24'h0, b} << sh);
   endfunction

   task automatic run_vec(input logic [41:0] v, input bit spoil);
      logic [1:0] vop   = v[41:40];
      logic [7:0] arg   = v[39:32];
      logic [1:0] off   = v[31:30];
      logic [7:0] old   = v[29:22];
      logic ext = v[21], pend = v[20], gen = v[19], gok = v[18], vtrap = v[17];
      logic edec = v[16];
      logic [7:0] emask = v[15:8];
      logic [31:0] psw0, opw0, e_psw, e_opw;
      int nw = 0, first_c = -1, last_c = -1, end_c = -1;
      bit got_done = 0, got_dec = 0;
      string tag;
      if (spoil) tag = "R10";
      else if (gen) tag = "R2";
      else if (vtrap) tag = "R3";
      else if (vop == 2'd0) tag = "R4/R5";
      else if (vop == 2'd1) tag = "R6";
      else tag = "R7";

      psw0 = {old, 24'h034567} | ({31'h0, ext} << 19);
      opw0 = 32'h11223344;
      if (vop == 2'd0) opw0 = put_byte(opw0, off, arg);
      mem[8'h41] = 32'h0000_0200;
      mem[8'h42] = {pend, 31'h0000_0300};
      mem[8'h45] = {31'h0, gok} << 23;
      mem[8'h80] = {31'h0, vtrap} << 30;
      mem[8'hC0] = psw0;
      mem[8'hE0] = opw0;

      @(posedge clk); #1;
      ctl_reg   = ({31'h0, gen} << 24) | 32'h100;
      opnd_addr = 24'h380 + {22'h0, off};
      imm       = (vop == 2'd0) ? 8'h5A : arg;
      op        = vop;
      start     = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (mem_req && mem_we) begin
            nw++;
            if (first_c < 0) first_c = i;
            last_c = i;
         end
         if (done || decline) begin
            got_done = done;
            got_dec  = decline;
            end_c    = i;
            break;
         end
         @(posedge clk); #1;
         if (spoil && i == 2) begin start = 1'b1; op = 2'd3; end
         else start = 1'b0;
      end
      @(posedge clk); #1;
      start = 1'b0;
      @(negedge clk);
      chk(!done && !decline, "R9 pulse width", {30'h0, done, decline}, 32'h0);

      chk(got_dec == edec && got_done == !edec, tag, {30'h0, got_done, got_dec}, {30'h0, !edec, edec});
      e_psw = edec ? psw0 : {emask, psw0[23:0]};
      chk(mem[8'hC0] == e_psw, tag, mem[8'hC0], e_psw);
      e_opw = (!edec && vop != 2'd0) ? put_byte(opw0, off, old) : opw0;
      chk(mem[8'hE0] == e_opw, "R11 operand word", mem[8'hE0], e_opw);
      if (edec) begin
         chk(nw == 0, "R8 writes on refusal", nw, 0);
      end else if (vop == 2'd0) begin
         chk(nw == 1 && last_c == end_c, "R8 write count", nw, 1);
      end else begin
         chk(nw == 2 && last_c == first_c + 1 && end_c == last_c, "R8 write order",
             {8'(nw), 8'(first_c), 8'(last_c), 8'(end_c)}, 32'h0200_0000);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !decline && !mem_req, "R1 reset state",
          {28'h0, busy, done, decline, mem_req}, 32'h0);

      for (int n = 0; n < NV; n++) run_vec(VEC[n], 1'b0);

      // R10: reserved op refused at once, no access
      @(posedge clk); #1;
      op = 2'd3; start = 1'b1;
      @(negedge clk);
      chk(decline && !mem_req && !done, "R10 reserved op", {29'h0, decline, mem_req, done}, 32'h4);
      @(posedge clk); #1; start = 1'b0;
      @(negedge clk);
      chk(!busy && !decline, "R10 stays idle", {30'h0, busy, decline}, 32'h0);

      // R10: start while busy ignored (AND vector rerun with a reserved start mid-flight)
      run_vec(VEC[9], 1'b1);

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule